// File: doc/BRIEF.md
# Memory ECC Error Status and Capture Unit

This unit sits beside a memory controller's ECC checker and address decoder. On every access that the checker flags, it receives a one-cycle report that can carry any mix of three error kinds: a correctable single-bit error, an uncorrectable multi-bit error, and a memory-select error. The report also carries the access's address, its 64-bit read data, its ECC byte and its attributes. The unit keeps sticky detect flags and per-kind mask and interrupt-enable bits. It tallies single-bit errors against a software threshold, and it latches a full snapshot of the first reported error until software releases it.

Software reaches every field through a word-indexed 32-bit register port that has byte enables. Reads are combinational from the register index. The interrupt output is high whenever a set detect flag has its enable bit on.

Top module: `ecc_err_monitor`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The detect register (index 0) holds sticky flags: bit 0 single-bit, bit 1 multi-bit, bit 2 memory-select, bit 3 multiple errors. A write with byte enable 0 clears each flag whose write-data bit is 1. A new detection in the same cycle wins over the clear.
- R3: Index 3 holds the single-bit count in bits [7:0] and the threshold in bits [15:8]. Byte enable 0 writes only the count, and byte enable 1 writes only the threshold.
- R4: Index 1 holds mask bits: bit 0 single-bit, bit 1 multi-bit, bit 2 memory-select. A masked kind sets no flag, changes no count and triggers no capture.
- R5: Each unmasked single-bit error raises the count by one. When the raised value equals the threshold, the single-bit flag is set and the count returns to zero. A threshold of zero never sets the flag.
- R6: The count saturates at 255.
- R7: A reported error (a multi-bit or memory-select error, or a single-bit error that reaches the threshold) loads the capture registers while the valid bit is clear. The capture registers are address (4), data high (5), data low (6) and ECC (7), plus an attribute word (8). The attribute word holds valid in bit [0], beat in [3:1], size in [5:4], source in [12:8] and type in [17:16]. Later errors leave the captured values untouched while valid is set.
- R8: Writing zero to a capture register clears it, and clearing the attribute word also clears valid. A non-zero write to a capture register has no effect.
- R9: A reported error that arrives while any detect flag is already set raises the multiple-errors flag.
- R10: Index 2 holds interrupt enables (bit 0 single-bit, bit 1 multi-bit, bit 2 memory-select). `irq` is high exactly when some flag among bits 0 to 2 is set and its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Error report strobe for one access |
| acc_sbe | input | 1 | Single-bit error on this access |
| acc_mbe | input | 1 | Multi-bit error on this access |
| acc_mse | input | 1 | Memory-select error on this access |
| acc_addr | input | 32 | Access address |
| acc_data | input | 64 | Raw read data |
| acc_ecc | input | 8 | Raw ECC byte |
| acc_beat | input | 3 | Data beat number |
| acc_size | input | 2 | Transaction size code |
| acc_src | input | 5 | Transaction source |
| acc_kind | input | 2 | Transaction type |
| csr_wr | input | 1 | Register write strobe |
| csr_idx | input | 4 | Register word index |
| csr_be | input | 4 | Byte enables for writes |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_idx` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `acc_valid` marks exactly the cycles that carry a report. They also assume the error-kind bits matter only in those cycles, and that register writes are single-cycle strobes. A cycle with a write and a report together is legal but is not exercised, so the stimulus never issues a register write in the same cycle as an error report. The stimulus reads registers only in idle cycles, one register index per cycle. It keeps every access field within its declared width, so the attribute packing can be predicted from the field values alone.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 4;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int ECC_W   = 8;
  localparam int CNT_W   = 8;
  localparam int BEAT_W  = 3;
  localparam int SIZE_W  = 2;
  localparam int SRC_W   = 5;
  localparam int KIND_W  = 2;
  localparam int NKINDS  = 3;
  localparam int NFLAGS  = NKINDS + 1;
  localparam int NCAP    = 5;

  localparam int FLG_SBE   = 0;
  localparam int FLG_MBE   = 1;
  localparam int FLG_MSE   = 2;
  localparam int FLG_MULTI = 3;

  localparam int CAP_ADDR = 0;
  localparam int CAP_DHI  = 1;
  localparam int CAP_DLO  = 2;
  localparam int CAP_ECC  = 3;
  localparam int CAP_ATTR = 4;

  typedef enum logic [IDX_W-1:0] {
    RG_STAT  = 4'd0,
    RG_MASK  = 4'd1,
    RG_IEN   = 4'd2,
    RG_SBE   = 4'd3,
    RG_CADDR = 4'd4,
    RG_CDHI  = 4'd5,
    RG_CDLO  = 4'd6,
    RG_CECC  = 4'd7,
    RG_CATTR = 4'd8
  } reg_idx_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [SRC_W-1:0]  src;
    logic [SIZE_W-1:0] size;
    logic [BEAT_W-1:0] beat;
  } err_attr_t;
endpackage

// File: rtl/sbe_tally.sv
module sbe_tally
  import ecc_mon_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  input  logic         wr_cnt_i,
  input  logic         wr_thr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic [W-1:0] thr_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] thr_o,
  output logic         report_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, thr_q, thr_d, cnt_inc;
  logic         cnt_en, thr_en;

  always_comb begin
    cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    report_o = hit_i && (cnt_inc == thr_q);
    cnt_en   = wr_cnt_i || hit_i;
    thr_en   = wr_thr_i;
    if (wr_cnt_i)      cnt_d = cnt_wdata_i;
    else if (report_o) cnt_d = '0;
    else               cnt_d = cnt_inc;
    thr_d = thr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (thr_en) thr_q <= thr_d;
    end
  end

  assign cnt_o = cnt_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/err_flags.sv
module err_flags
  import ecc_mon_pkg::*;
#(
  parameter int NK = NKINDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NK-1:0] hit_i,
  input  logic          clr_wr_i,
  input  logic [NK:0]   clr_mask_i,
  output logic [NK:0]   flags_o
);
  logic [NK:0] flags_q, flags_d;
  logic        any_new, any_prior;

  assign any_new   = |hit_i;
  assign any_prior = |flags_q;

  for (genvar k = 0; k < NK; k++) begin : g_kind
    always_comb
      flags_d[k] = hit_i[k] | (flags_q[k] & ~(clr_wr_i & clr_mask_i[k]));
  end

  always_comb
    flags_d[NK] = (any_new & any_prior) | (flags_q[NK] & ~(clr_wr_i & clr_mask_i[NK]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/err_capture.sv
module err_capture
  import ecc_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              event_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] dhi_i,
  input  logic [HALF_W-1:0] dlo_i,
  input  logic [ECC_W-1:0]  ecc_i,
  input  err_attr_t         attr_i,
  input  logic [NCAP-1:0]   clr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [HALF_W-1:0] dhi_o,
  output logic [HALF_W-1:0] dlo_o,
  output logic [ECC_W-1:0]  ecc_o,
  output err_attr_t         attr_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [HALF_W-1:0] dhi_q, dhi_d, dlo_q, dlo_d;
  logic [ECC_W-1:0]  ecc_q, ecc_d;
  err_attr_t         attr_q, attr_d;
  logic              valid_q, valid_d;
  logic              load;

  assign load = event_i && !valid_q;

  always_comb begin
    addr_d  = addr_q;
    dhi_d   = dhi_q;
    dlo_d   = dlo_q;
    ecc_d   = ecc_q;
    attr_d  = attr_q;
    valid_d = valid_q;
    if (load) begin
      addr_d  = addr_i;
      dhi_d   = dhi_i;
      dlo_d   = dlo_i;
      ecc_d   = ecc_i;
      attr_d  = attr_i;
      valid_d = 1'b1;
    end else begin
      if (clr_i[CAP_ADDR]) addr_d = '0;
      if (clr_i[CAP_DHI])  dhi_d  = '0;
      if (clr_i[CAP_DLO])  dlo_d  = '0;
      if (clr_i[CAP_ECC])  ecc_d  = '0;
      if (clr_i[CAP_ATTR]) begin
        attr_d  = '0;
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      dhi_q   <= '0;
      dlo_q   <= '0;
      ecc_q   <= '0;
      attr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      dhi_q   <= dhi_d;
      dlo_q   <= dlo_d;
      ecc_q   <= ecc_d;
      attr_q  <= attr_d;
      valid_q <= valid_d;
    end
  end

  assign addr_o  = addr_q;
  assign dhi_o   = dhi_q;
  assign dlo_o   = dlo_q;
  assign ecc_o   = ecc_q;
  assign attr_o  = attr_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ecc_err_monitor.sv
module ecc_err_monitor
  import ecc_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_sbe,
  input  logic              acc_mbe,
  input  logic              acc_mse,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [ECC_W-1:0]  acc_ecc,
  input  logic [BEAT_W-1:0] acc_beat,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [SRC_W-1:0]  acc_src,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic              csr_wr,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [3:0]        csr_be,
  input  logic [REG_W-1:0]  csr_wdata,
  output logic [REG_W-1:0]  csr_rdata,
  output logic              irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // write decode
  logic wr_stat, wr_mask, wr_ien, wr_sbe, wdata_zero;
  logic [NCAP-1:0] cap_clr;

  assign wdata_zero = (csr_wdata == '0);
  assign wr_stat = csr_wr && (csr_idx == RG_STAT);
  assign wr_mask = csr_wr && (csr_idx == RG_MASK) && csr_be[0];
  assign wr_ien  = csr_wr && (csr_idx == RG_IEN)  && csr_be[0];
  assign wr_sbe  = csr_wr && (csr_idx == RG_SBE);

  for (genvar c = 0; c < NCAP; c++) begin : g_capclr
    assign cap_clr[c] = csr_wr && wdata_zero &&
                        (csr_idx == IDX_W'(int'(RG_CADDR) + c));
  end

  // mask and interrupt-enable registers
  logic [NKINDS-1:0] dis_q, dis_d, ien_q, ien_d;

  always_comb begin
    dis_d = csr_wdata[NKINDS-1:0];
    ien_d = csr_wdata[NKINDS-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dis_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_mask) dis_q <= dis_d;
      if (wr_ien)  ien_q <= ien_d;
    end
  end

  // single-bit tally
  logic             sbe_hit, sbe_report;
  logic [CNT_W-1:0] sbe_cnt, sbe_thr;

  assign sbe_hit = acc_valid && acc_sbe && !dis_q[FLG_SBE];

  sbe_tally #(.W(CNT_W)) u_tally (
    .clk         (clk),
    .rst_n       (rst_q),
    .hit_i       (sbe_hit),
    .wr_cnt_i    (wr_sbe && csr_be[0]),
    .wr_thr_i    (wr_sbe && csr_be[1]),
    .cnt_wdata_i (csr_wdata[CNT_W-1:0]),
    .thr_wdata_i (csr_wdata[8 +: CNT_W]),
    .cnt_o       (sbe_cnt),
    .thr_o       (sbe_thr),
    .report_o    (sbe_report)
  );

  // detect flags
  logic [NKINDS-1:0] hits;
  logic [NFLAGS-1:0] flags_q;
  logic              err_event;

  always_comb begin
    hits[FLG_SBE] = sbe_report;
    hits[FLG_MBE] = acc_valid && acc_mbe && !dis_q[FLG_MBE];
    hits[FLG_MSE] = acc_valid && acc_mse && !dis_q[FLG_MSE];
  end
  assign err_event = |hits;

  err_flags #(.NK(NKINDS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_q),
    .hit_i      (hits),
    .clr_wr_i   (wr_stat && csr_be[0]),
    .clr_mask_i (csr_wdata[NFLAGS-1:0]),
    .flags_o    (flags_q)
  );

  // first-error capture
  err_attr_t         acc_attr, cap_attr;
  logic [ADDR_W-1:0] cap_addr;
  logic [HALF_W-1:0] cap_dhi, cap_dlo;
  logic [ECC_W-1:0]  cap_ecc;
  logic              cap_valid;

  always_comb begin
    acc_attr.kind = acc_kind;
    acc_attr.src  = acc_src;
    acc_attr.size = acc_size;
    acc_attr.beat = acc_beat;
  end

  err_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_q),
    .event_i (err_event),
    .addr_i  (acc_addr),
    .dhi_i   (acc_data[DATA_W-1:HALF_W]),
    .dlo_i   (acc_data[HALF_W-1:0]),
    .ecc_i   (acc_ecc),
    .attr_i  (acc_attr),
    .clr_i   (cap_clr),
    .addr_o  (cap_addr),
    .dhi_o   (cap_dhi),
    .dlo_o   (cap_dlo),
    .ecc_o   (cap_ecc),
    .attr_o  (cap_attr),
    .valid_o (cap_valid)
  );

  // read mux
  logic [REG_W-1:0] attr_word;

  always_comb begin
    attr_word        = '0;
    attr_word[0]     = cap_valid;
    attr_word[3:1]   = cap_attr.beat;
    attr_word[5:4]   = cap_attr.size;
    attr_word[12:8]  = cap_attr.src;
    attr_word[17:16] = cap_attr.kind;
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_idx)
      RG_STAT:  csr_rdata[NFLAGS-1:0] = flags_q;
      RG_MASK:  csr_rdata[NKINDS-1:0] = dis_q;
      RG_IEN:   csr_rdata[NKINDS-1:0] = ien_q;
      RG_SBE:   csr_rdata[15:0]       = {sbe_thr, sbe_cnt};
      RG_CADDR: csr_rdata             = cap_addr;
      RG_CDHI:  csr_rdata             = cap_dhi;
      RG_CDLO:  csr_rdata             = cap_dlo;
      RG_CECC:  csr_rdata[ECC_W-1:0]  = cap_ecc;
      RG_CATTR: csr_rdata             = attr_word;
      default:  csr_rdata             = '0;
    endcase
  end

  assign irq = |(flags_q[NKINDS-1:0] & ien_q);
endmodule

// File: rtl/ecc_err_monitor_chk.sv
module ecc_err_monitor_chk
  import ecc_mon_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic              csr_wr,
  input logic [IDX_W-1:0]  csr_idx,
  input logic [3:0]        csr_be,
  input logic [REG_W-1:0]  csr_wdata,
  input logic              acc_valid,
  input logic              acc_mbe,
  input logic              acc_mse,
  input logic [NFLAGS-1:0] flags_q,
  input logic [NKINDS-1:0] dis_q,
  input logic [NKINDS-1:0] ien_q,
  input logic              irq,
  input logic              cap_valid,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [CNT_W-1:0]  sbe_cnt,
  input logic [CNT_W-1:0]  sbe_thr
);
  logic stat_clr0, cap_zero_wr, cnt_wr;

  assign stat_clr0   = csr_wr && csr_idx == 4'd0 && csr_be[0] && csr_wdata[0];
  assign cap_zero_wr = csr_wr && csr_wdata == '0 && (csr_idx == 4'd4 || csr_idx == 4'd8);
  assign cnt_wr      = csr_wr && csr_idx == 4'd3 && csr_be[0];

  // R2
  sbe_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (flags_q[0] && !stat_clr0) |=> flags_q[0]);

  // R4
  mbe_masked_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && acc_mbe && dis_q[1] && !flags_q[1]) |=> !flags_q[1]);

  // R6
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sbe_cnt == 8'hFF && sbe_thr != 8'hFF && !cnt_wr) |=> sbe_cnt == 8'hFF);

  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cap_valid && !cap_zero_wr) |=> $stable(cap_addr));

  // R9
  multi_flag_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && acc_mse && !dis_q[2] && flags_q != '0) |=> flags_q[3]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ien_q == '0) |-> !irq);
endmodule

bind ecc_err_monitor ecc_err_monitor_chk u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .csr_wr    (csr_wr),
  .csr_idx   (csr_idx),
  .csr_be    (csr_be),
  .csr_wdata (csr_wdata),
  .acc_valid (acc_valid),
  .acc_mbe   (acc_mbe),
  .acc_mse   (acc_mse),
  .flags_q   (flags_q),
  .dis_q     (dis_q),
  .ien_q     (ien_q),
  .irq       (irq),
  .cap_valid (cap_valid),
  .cap_addr  (cap_addr),
  .sbe_cnt   (sbe_cnt),
  .sbe_thr   (sbe_thr)
);

// File: tb/ecc_err_monitor_test.sv
module ecc_err_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_sbe, acc_mbe, acc_mse;
  logic [31:0] acc_addr;
  logic [63:0] acc_data;
  logic [7:0]  acc_ecc;
  logic [2:0]  acc_beat;
  logic [1:0]  acc_size;
  logic [4:0]  acc_src;
  logic [1:0]  acc_kind;
  logic        csr_wr;
  logic [3:0]  csr_idx;
  logic [3:0]  csr_be;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic        rd_req = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ecc_err_monitor uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_sbe(acc_sbe), .acc_mbe(acc_mbe), .acc_mse(acc_mse),
    .acc_addr(acc_addr), .acc_data(acc_data), .acc_ecc(acc_ecc),
    .acc_beat(acc_beat), .acc_size(acc_size), .acc_src(acc_src), .acc_kind(acc_kind),
    .csr_wr(csr_wr), .csr_idx(csr_idx), .csr_be(csr_be), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq(irq)
  );

  // monitor: compares each requested read against the scoreboard queue
  always @(negedge clk) begin
    #2;
    if (rd_req && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (csr_rdata !== e) begin
        errors++;
        $display("FAIL %s idx=%0d actual=%h expected=%h", t, csr_idx, csr_rdata, e);
      end
    end
  end

  task automatic rd(input logic [3:0] idx, input logic [31:0] e, input string t);
    @(negedge clk);
    csr_idx = idx;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_idx = idx; csr_be = be; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = 32'h0;
  endtask

  task automatic ev(input logic s, input logic m, input logic ms,
                    input logic [31:0] a, input logic [63:0] d, input logic [7:0] e,
                    input logic [2:0] bt, input logic [1:0] sz,
                    input logic [4:0] sr, input logic [1:0] kd);
    @(negedge clk);
    acc_valid = 1'b1; acc_sbe = s; acc_mbe = m; acc_mse = ms;
    acc_addr = a; acc_data = d; acc_ecc = e;
    acc_beat = bt; acc_size = sz; acc_src = sr; acc_kind = kd;
    @(negedge clk);
    acc_valid = 1'b0; acc_sbe = 1'b0; acc_mbe = 1'b0; acc_mse = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    #2;
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  function automatic logic [31:0] attr_of(input logic [2:0] bt, input logic [1:0] sz,
                                          input logic [4:0] sr, input logic [1:0] kd);
    return 32'h1 | (32'(bt) << 1) | (32'(sz) << 4) | (32'(sr) << 8) | (32'(kd) << 16);
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [31:0] A1 = 32'h0000_2A40;
  localparam logic [63:0] D1 = 64'hDEADBEEF_01234567;
  localparam logic [31:0] A2 = 32'h0000_4440;
  localparam logic [63:0] D2 = 64'h0BAD_F00D_CAFE_0042;

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_sbe = 1'b0; acc_mbe = 1'b0; acc_mse = 1'b0;
    acc_addr = '0; acc_data = '0; acc_ecc = '0;
    acc_beat = '0; acc_size = '0; acc_src = '0; acc_kind = '0;
    csr_wr = 1'b0; csr_idx = '0; csr_be = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'd0, 32'h0, "R1 detect");
    rd(4'd3, 32'h0, "R1 tally");
    rd(4'd8, 32'h0, "R1 attr");
    chk_irq(1'b0, "R1 irq");

    // R3 threshold byte only
    wr(4'd3, 4'b0010, 32'h0000_0300);
    rd(4'd3, 32'h0000_0300, "R3 thr write");

    // R5 counting below threshold
    ev(1, 0, 0, 32'h1111, 64'h1, 8'h1, 3'd0, 2'd0, 5'd0, 2'd0);
    ev(1, 0, 0, 32'h1111, 64'h1, 8'h1, 3'd0, 2'd0, 5'd0, 2'd0);
    rd(4'd3, 32'h0000_0302, "R5 count");
    rd(4'd0, 32'h0, "R5 no flag");

    // R3 count byte only
    wr(4'd3, 4'b0001, 32'hFFFF_FF05);
    rd(4'd3, 32'h0000_0305, "R3 cnt write");
    wr(4'd3, 4'b0001, 32'h0000_0001);

    // R5 reaching threshold, R7 capture
    ev(1, 0, 0, 32'h1111, 64'h1, 8'h1, 3'd0, 2'd0, 5'd0, 2'd0);
    ev(1, 0, 0, A1, D1, 8'h5C, 3'd5, 2'd2, 5'h13, 2'd1);
    rd(4'd3, 32'h0000_0300, "R5 reset on hit");
    rd(4'd0, 32'h1, "R5 flag");
    rd(4'd4, A1, "R7 addr");
    rd(4'd5, D1[63:32], "R7 data hi");
    rd(4'd6, D1[31:0], "R7 data lo");
    rd(4'd7, 32'h5C, "R7 ecc");
    rd(4'd8, attr_of(3'd5, 2'd2, 5'h13, 2'd1), "R7 attr");

    // R10 interrupt gating
    chk_irq(1'b0, "R10 disabled");
    wr(4'd2, 4'b0001, 32'h1);
    chk_irq(1'b1, "R10 sbe enabled");
    wr(4'd2, 4'b0001, 32'h2);
    chk_irq(1'b0, "R10 other enable");

    // R9 multiple errors, R7 hold
    ev(0, 1, 0, 32'h3000, 64'h3, 8'h3, 3'd1, 2'd1, 5'd1, 2'd1);
    rd(4'd0, 32'hB, "R9 multi");
    chk_irq(1'b1, "R10 mbe");
    rd(4'd4, A1, "R7 held");

    // R2 write-one-to-clear
    wr(4'd0, 4'b0001, 32'h1);
    rd(4'd0, 32'hA, "R2 partial clear");
    wr(4'd0, 4'b0001, 32'hF);
    rd(4'd0, 32'h0, "R2 full clear");
    chk_irq(1'b0, "R10 cleared");

    // R8 capture clearing
    wr(4'd4, 4'hF, 32'h1234);
    rd(4'd4, A1, "R8 nonzero ignored");
    wr(4'd8, 4'hF, 32'h0);
    rd(4'd8, 32'h0, "R8 attr cleared");
    wr(4'd4, 4'hF, 32'h0);
    rd(4'd4, 32'h0, "R8 addr cleared");

    // R7 recapture after release, R9 no multi on clean flags
    ev(0, 0, 1, A2, D2, 8'hA1, 3'd0, 2'd1, 5'd2, 2'd3);
    rd(4'd0, 32'h4, "R9 single report");
    rd(4'd8, attr_of(3'd0, 2'd1, 5'd2, 2'd3), "R7 recapture attr");
    rd(4'd4, A2, "R7 recapture addr");
    wr(4'd0, 4'b0001, 32'hF);

    // R4 masks
    wr(4'd1, 4'b0001, 32'h2);
    ev(0, 1, 0, 32'h5000, 64'h5, 8'h5, 3'd0, 2'd0, 5'd0, 2'd0);
    rd(4'd0, 32'h0, "R4 mbe masked");
    wr(4'd1, 4'b0001, 32'h1);
    for (int i = 0; i < 3; i++)
      ev(1, 0, 0, 32'h6000, 64'h6, 8'h6, 3'd0, 2'd0, 5'd0, 2'd0);
    rd(4'd3, 32'h0000_0300, "R4 sbe not counted");
    rd(4'd0, 32'h0, "R4 sbe no flag");
    rd(4'd4, A2, "R4 no capture");
    wr(4'd1, 4'b0001, 32'h0);

    // R6 saturation, R5 zero threshold
    wr(4'd3, 4'b0011, 32'h0000_00FE);
    ev(1, 0, 0, 32'h7000, 64'h7, 8'h7, 3'd0, 2'd0, 5'd0, 2'd0);
    rd(4'd3, 32'h0000_00FF, "R6 reach max");
    ev(1, 0, 0, 32'h7000, 64'h7, 8'h7, 3'd0, 2'd0, 5'd0, 2'd0);
    rd(4'd3, 32'h0000_00FF, "R6 saturated");
    rd(4'd0, 32'h0, "R5 zero threshold");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule